// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block sits beside an asynchronous SRAM port and turns a special chain of read accesses into a command. It samples the active-low chip select, output enable and write enable and the address bus into its own clock. It counts how far a chain of reads to fixed key addresses has advanced. Five key reads in a fixed order open the chain. The sixth read then picks one of four commands:

- store to nonvolatile storage
- recall from nonvolatile storage
- turn off automatic store
- turn on automatic store

When a command is picked, the block raises a one-cycle strobe with a 2-bit code for the store/recall controller.

Any write, and any read that is not the expected next step, ends the chain. While the controller reports busy, the detector stays idle and ignores every access. Only the low 14 address bits take part in the comparison.

Top module: `rdseq_cmd_detect`

## Requirements
- R1: A command fires only after five read events in a row whose low 14 address bits are, in this order, 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F.
- R2: The sixth read selects the command through its low 14 address bits: 0x0FC0 gives code 0 (store), 0x0C63 gives code 1 (recall), 0x03F8 gives code 2 (automatic store off) and 0x07F0 gives code 3 (automatic store on). `cmd_stb` is high for exactly one cycle, `cmd_code` is valid in that cycle, and `cmd_code` reads 0 while `cmd_stb` is low.
- R3: A read event is either of two things while `we_n` is high: a falling edge of `ce_n`, or a falling edge of `oe_n` while `ce_n` is low. `oe_n` does not have to be low for a chip-select read to count.
- R4: A write event sends the detector back to idle and issues no command. A write event is a falling edge of `ce_n` while `we_n` is low, or a falling edge of `we_n` while `ce_n` is low.
- R5: A read that does not match the expected next step aborts the chain. If that address is 0x0E38, it counts as the first step of a new chain; otherwise the detector goes idle.
- R6: A sixth read that matches none of the four command addresses issues no command and ends the chain. The R5 restart rule still applies to it.
- R7: Address bit 14 has no effect on detection.
- R8: While `busy` is high, the detector is held idle and no access during that time produces a command or advances the chain.
- R9: `cmd_stb` rises at the third rising clock edge after the triggering input edge has been applied (two synchroniser stages plus one output register).
- R10: After reset, `cmd_stb` and `cmd_code` are 0 and the detector is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W (15) | Access address; only the low KEY_W (14) bits are compared |
| busy | input | 1 | Store/recall controller busy; holds the detector idle |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_code | output | 2 | Command code, valid while `cmd_stb` is high |

## Verification
The step counter is the only state, and it is hidden. A wrong count therefore shows at the ports only when a sixth read arrives. At that point it shows as a strobe that is missing, a strobe that should not be there, or a wrong code, three clock edges after the input edge.

Each access in the bench is followed by a comparison of the running strobe count and the last code against a reference model. A stale or skipped step is therefore caught no later than the end of the next complete chain. Aborting sequences are always followed by the remaining valid steps, so that a chain that failed to abort would show up as an extra command.

// File: rtl/rdseq_cmd_detect.sv
module rdseq_cmd_detect #(
  parameter int ADDR_W = 15,
  parameter int KEY_W  = 14,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              cmd_stb,
  output logic [1:0]        cmd_code
);
  localparam int CW     = 3 + KEY_W;
  localparam int LAST   = 5;
  localparam logic [CW-1:0] IDLE_V = {3'b111, {KEY_W{1'b0}}};

  function automatic logic [KEY_W-1:0] step_key(input logic [2:0] i);
    case (i)
      3'd0:    return KEY_W'(16'h0E38);
      3'd1:    return KEY_W'(16'h31C7);
      3'd2:    return KEY_W'(16'h03E0);
      3'd3:    return KEY_W'(16'h3C1F);
      default: return KEY_W'(16'h303F);
    endcase
  endfunction

  function automatic logic [KEY_W-1:0] cmd_key(input logic [1:0] c);
    case (c)
      2'd0:    return KEY_W'(16'h0FC0);
      2'd1:    return KEY_W'(16'h0C63);
      2'd2:    return KEY_W'(16'h03F8);
      default: return KEY_W'(16'h07F0);
    endcase
  endfunction

  logic [CW-1:0] sync_q [SYNC_N];
  logic          ce_d, oe_d, we_d;
  logic [2:0]    step_cnt, step_nxt;
  logic          fire, hit;
  logic [1:0]    fire_code, hit_code;
  logic          unused_hi;

  assign unused_hi = ^addr[ADDR_W-1:KEY_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_N; i++) sync_q[i] <= IDLE_V;
    end else begin
      sync_q[0] <= {ce_n, oe_n, we_n, addr[KEY_W-1:0]};
      for (int i = 1; i < SYNC_N; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  wire             ce_s = sync_q[SYNC_N-1][CW-1];
  wire             oe_s = sync_q[SYNC_N-1][CW-2];
  wire             we_s = sync_q[SYNC_N-1][CW-3];
  wire [KEY_W-1:0] key  = sync_q[SYNC_N-1][KEY_W-1:0];

  wire ce_fall  = ce_d & ~ce_s;
  wire oe_fall  = ~ce_s & oe_d & ~oe_s;
  wire we_fall  = ~ce_s & we_d & ~we_s;
  wire is_write = (ce_fall & ~we_s) | we_fall;
  wire is_read  = (ce_fall | oe_fall) & we_s;

  always_comb begin
    hit = 1'b0;
    hit_code = 2'd0;
    for (int c = 0; c < 4; c++)
      if (key == cmd_key(2'(c))) begin
        hit = 1'b1;
        hit_code = 2'(c);
      end
  end

  always_comb begin
    step_nxt  = step_cnt;
    fire      = 1'b0;
    fire_code = 2'd0;
    if (busy || is_write) begin
      step_nxt = 3'd0;
    end else if (is_read) begin
      if (step_cnt < 3'(LAST) && key == step_key(step_cnt)) begin
        step_nxt = step_cnt + 3'd1;
      end else if (step_cnt == 3'(LAST) && hit) begin
        fire      = 1'b1;
        fire_code = hit_code;
        step_nxt  = 3'd0;
      end else begin
        step_nxt = (key == step_key(3'd0)) ? 3'd1 : 3'd0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d     <= 1'b1;
      oe_d     <= 1'b1;
      we_d     <= 1'b1;
      step_cnt <= 3'd0;
      cmd_stb  <= 1'b0;
      cmd_code <= 2'd0;
    end else begin
      ce_d     <= ce_s;
      oe_d     <= oe_s;
      we_d     <= we_s;
      step_cnt <= step_nxt;
      cmd_stb  <= fire;
      cmd_code <= fire_code;
    end
  end
endmodule

// File: rtl/rdseq_cmd_detect_chk.sv
module rdseq_cmd_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       cmd_stb,
  input logic [1:0] cmd_code,
  input logic [2:0] step_cnt
);
  assert_stb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  assert_code_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_stb |-> cmd_code == 2'd0);

  assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!cmd_stb && step_cnt == 3'd0));

  assert_fire_after_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_stb) |-> $past(step_cnt) == 3'd5);

  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt <= 3'd5);

  assert_step_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_cnt != $past(step_cnt)) |-> (step_cnt == $past(step_cnt) + 3'd1 || step_cnt <= 3'd1));
endmodule

bind rdseq_cmd_detect rdseq_cmd_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .cmd_stb(cmd_stb), .cmd_code(cmd_code), .step_cnt(step_cnt)
);

// File: tb/test_rdseq_cmd_detect.sv
`timescale 1ns/1ps
module test_rdseq_cmd_detect;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [14:0] addr = '0;
  logic cmd_stb;
  logic [1:0] cmd_code;

  rdseq_cmd_detect i_rdseq_cmd_detect (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .busy(busy), .cmd_stb(cmd_stb), .cmd_code(cmd_code));

  always #4 clk = ~clk;

  localparam logic [13:0] PRE [5] = '{14'h0E38, 14'h31C7, 14'h03E0, 14'h3C1F, 14'h303F};
  localparam logic [13:0] CMDK [4] = '{14'h0FC0, 14'h0C63, 14'h03F8, 14'h07F0};

  int total = 0, bad = 0;
  int stb_cnt = 0, exp_cnt = 0;
  logic [1:0] last_code = 0, exp_code = 0;
  logic [2:0] exp_st = 0;
  bit code_err = 0;

  always @(negedge clk) if (rst_n) begin
    if (cmd_stb) begin stb_cnt++; last_code = cmd_code; end
    else if (cmd_code != 2'd0) code_err = 1;
  end

  function automatic logic [5:0] model_step(input logic [2:0] st, input logic [13:0] k,
                                            input bit wr, input bit bz);
    if (bz || wr) return {3'b000, 3'd0};
    if (st < 5 && k == PRE[st]) return {3'b000, st + 3'd1};
    if (st == 5)
      for (int c = 0; c < 4; c++)
        if (k == CMDK[c]) return {1'b1, 2'(c), 3'd0};
    return {3'b000, (k == PRE[0]) ? 3'd1 : 3'd0};
  endfunction

  task automatic apply(input logic [13:0] k, input bit wr);
    logic [5:0] r;
    r = model_step(exp_st, k, wr, busy);
    exp_st = r[2:0];
    if (r[5]) begin exp_cnt++; exp_code = r[4:3]; end
  endtask

  task automatic check(input string tag);
    total++;
    if (stb_cnt != exp_cnt || last_code != exp_code || code_err) begin
      bad++;
      $display("FAIL %s: strobes=%0d code=%0d codeerr=%0d expected strobes=%0d code=%0d codeerr=0",
               tag, stb_cnt, last_code, code_err, exp_cnt, exp_code);
      code_err = 0;
    end
  endtask

  task automatic ce_access(input logic [14:0] a, input bit wr, input string tag);
    @(negedge clk); addr = a; we_n = ~wr;
    @(negedge clk); ce_n = 1'b0;
    repeat (4) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1;
    repeat (3) @(negedge clk);
    apply(a[13:0], wr);
    check(tag);
  endtask

  task automatic ce_open(input logic [14:0] a, input string tag);
    @(negedge clk); addr = a;
    @(negedge clk); ce_n = 1'b0;
    repeat (5) @(negedge clk);
    apply(a[13:0], 1'b0);
    check(tag);
  endtask

  task automatic ce_close();
    @(negedge clk); ce_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic oe_step(input logic [14:0] a, input bit lat, input string tag);
    logic [3:0] seen;
    @(negedge clk); addr = a;
    @(negedge clk); oe_n = 1'b0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); seen[i] = cmd_stb; end
    oe_n = 1'b1;
    repeat (3) @(negedge clk);
    apply(a[13:0], 1'b0);
    check(tag);
    if (lat) begin
      total++;
      if (seen != 4'b0100) begin
        bad++;
        $display("FAIL R9 latency: strobe per edge=%b expected=0100", seen);
      end
    end
  endtask

  task automatic we_write(input string tag);
    @(negedge clk); we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
    apply(addr[13:0], 1'b1);
    check(tag);
  endtask

  task automatic prefix(input int upto, input bit top);
    for (int i = 0; i < upto; i++) ce_access({top, PRE[i]}, 1'b0, "R1 prefix");
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [14:0] a;
    int r;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if (cmd_stb !== 1'b0 || cmd_code !== 2'd0) begin
      bad++;
      $display("FAIL R10 reset: stb=%b code=%0d expected stb=0 code=0", cmd_stb, cmd_code);
    end

    for (int c = 0; c < 4; c++) begin
      prefix(5, 1'b0);
      ce_access({1'b0, CMDK[c]}, 1'b0, "R2 command code");
    end

    ce_open({1'b0, PRE[0]}, "R3 ce read with oe high");
    for (int i = 1; i < 5; i++) oe_step({1'b0, PRE[i]}, 1'b0, "R3 oe read");
    oe_step({1'b0, CMDK[1]}, 1'b1, "R3 oe sixth read");
    ce_close();

    prefix(5, 1'b1);
    ce_access({1'b1, CMDK[3]}, 1'b0, "R7 top bit set");

    prefix(3, 1'b0);
    ce_access({1'b0, PRE[3]}, 1'b1, "R4 ce write");
    ce_access({1'b0, PRE[3]}, 1'b0, "R4 after write");
    ce_access({1'b0, PRE[4]}, 1'b0, "R4 after write");
    ce_access({1'b0, CMDK[0]}, 1'b0, "R4 no command after write");

    ce_open({1'b0, PRE[0]}, "R4 oe session");
    oe_step({1'b0, PRE[1]}, 1'b0, "R4 oe session");
    we_write("R4 we write");
    for (int i = 2; i < 5; i++) oe_step({1'b0, PRE[i]}, 1'b0, "R4 after we write");
    oe_step({1'b0, CMDK[2]}, 1'b0, "R4 no command after we write");
    ce_close();

    prefix(2, 1'b0);
    ce_access({1'b0, 14'h1555}, 1'b0, "R5 wrong step");
    for (int i = 2; i < 5; i++) ce_access({1'b0, PRE[i]}, 1'b0, "R5 after abort");
    ce_access({1'b0, CMDK[0]}, 1'b0, "R5 no command after abort");

    prefix(4, 1'b0);
    ce_access({1'b0, PRE[0]}, 1'b0, "R5 restart key");
    for (int i = 1; i < 5; i++) ce_access({1'b0, PRE[i]}, 1'b0, "R5 restarted chain");
    ce_access({1'b0, CMDK[1]}, 1'b0, "R5 restarted chain fires");

    prefix(5, 1'b0);
    ce_access({1'b0, 14'h1234}, 1'b0, "R6 bad sixth");
    ce_access({1'b0, CMDK[0]}, 1'b0, "R6 no late command");
    prefix(5, 1'b0);
    ce_access({1'b0, PRE[0]}, 1'b0, "R6 sixth equals first key");
    for (int i = 1; i < 5; i++) ce_access({1'b0, PRE[i]}, 1'b0, "R6 chain after restart");
    ce_access({1'b0, CMDK[2]}, 1'b0, "R6 restarted chain fires");

    busy = 1'b1;
    prefix(5, 1'b0);
    ce_access({1'b0, CMDK[0]}, 1'b0, "R8 busy full chain");
    busy = 1'b0;
    prefix(3, 1'b0);
    busy = 1'b1;
    ce_access({1'b0, PRE[3]}, 1'b0, "R8 busy mid chain");
    busy = 1'b0;
    ce_access({1'b0, PRE[4]}, 1'b0, "R8 after busy");
    ce_access({1'b0, CMDK[0]}, 1'b0, "R8 no command after busy");

    for (int n = 0; n < 400; n++) begin
      r = $urandom % 10;
      if (r < 6) a[13:0] = (exp_st == 5) ? CMDK[$urandom % 4] : PRE[exp_st];
      else if (r == 6) a[13:0] = PRE[0];
      else a[13:0] = 14'($urandom);
      a[14] = 1'($urandom);
      if (r == 8) ce_access(a, 1'b1, "R4 random write");
      else ce_access(a, 1'b0, "R1 random read");
    end

    summary();
    $finish;
  end
endmodule